// File: doc/BRIEF.md
# FRAM Power-Up Validation Sequencer

After reset this block runs one fixed sequence of SPI transactions against an attached ferroelectric memory. It decides whether the device is present and whether the array holds settings from an earlier session. It reads the device identifier first and stops with a fault if the identifier is wrong. It then reads the first byte of the array and compares it with a marker value. If the marker is missing, the block stores the marker at address 0 and clears every other location in the same write burst.

Other logic waits for `done`. The `empty` flag then tells it whether the stored settings are freshly cleared, so that defaults must be used, or hold earlier values. `next_free` gives the first address that a later allocator may hand out. The SPI side is a mode-0 byte engine driven by a request/acknowledge handshake, with chip select under sequencer control. Reads and writes after start-up are handled elsewhere.

Top module: `fram_boot_seq`

## Requirements
- R1: While reset is high and in the cycle after it falls, `spi_cs_n` is 1, `spi_sck` is 0, and `done`, `dev_fault`, `empty` and `next_free` are all 0.
- R2: The first frame is opcode 0x9F followed by four clocked bytes. These are joined most significant byte first into a 32-bit identifier, and the whole value is compared with `EXPECTED_ID` (default 0x047F0302).
- R3: On an identifier mismatch the block opens no further frame and writes nothing. It ends with `dev_fault`=1, `empty`=0 and `next_free`=0.
- R4: The second frame is exactly four bytes: opcode 0x03, two address bytes of 0x00, and one data byte. That data byte is taken as the content of address 0.
- R5: If the byte read equals `MARKER` (default 42), `empty` ends 0 and no further frame is opened.
- R6: If the byte read differs from `MARKER`, `empty` ends 1. The block sends a one-byte frame with opcode 0x06, then one frame made of opcode 0x02, address bytes 0x00 0x00, `MARKER`, and `MEM_BYTES`-1 bytes of 0x00. Chip select is raised only after the last of these.
- R7: Between any two frames, and between reset release and the first frame, `spi_cs_n` stays high for at least `GAP_CYCLES` clock cycles.
- R8: Once `done` rises it stays 1 until reset, and `dev_fault` and `empty` no longer change. On success `next_free` is 1.
- R9: The SPI bus runs in mode 0. `spi_sck` idles low and is low whenever chip select is high. Data is shifted most significant bit first, `spi_mosi` is stable at each rising edge, and `spi_miso` is sampled on the rising edge.
- R10: The sequencer hands the byte engine one byte at a time. A request is issued only while the engine is idle, and chip select is low during every byte, so each frame carries exactly the byte count listed in R2, R4 and R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a new sequence when released |
| spi_sck | output | 1 | SPI serial clock, idles low |
| spi_mosi | output | 1 | SPI data to the memory |
| spi_miso | input | 1 | SPI data from the memory |
| spi_cs_n | output | 1 | Active-low chip select |
| done | output | 1 | Sequence finished; held until reset |
| dev_fault | output | 1 | Identifier did not match |
| empty | output | 1 | Marker was absent, so the array has been cleared |
| next_free | output | $clog2(MEM_BYTES) | First address available for allocation |

## Verification
The bench builds the block with `MEM_BYTES`=64, `SCK_DIV`=2 and `GAP_CYCLES`=12. The 64-byte array puts the complete clearing burst within a few thousand cycles. This lets the bench compare the exact frame length and every location of the modelled memory after the fill. It also makes sure the last zero lands at the top address and no further byte follows. Twelve cycles at 200 MHz equal a 60 ns deselect time, so the gap check runs at a realistic margin. A fast serial clock keeps the identifier-mismatch, marker-present and marker-absent runs short enough to repeat. Both a byte-swapped identifier and an identifier wrong only in its lowest byte are tried.

// File: rtl/fram_boot_pkg.sv
package fram_boot_pkg;

    localparam logic [7:0] OPC_READ_ID  = 8'h9F;
    localparam logic [7:0] OPC_READ     = 8'h03;
    localparam logic [7:0] OPC_WRITE    = 8'h02;
    localparam logic [7:0] OPC_WR_EN    = 8'h06;
    localparam logic [7:0] FILL_BYTE    = 8'h00;

    typedef enum logic [4:0] {
        ST_ID_OP,
        ST_ID_DATA,
        ST_ID_CHK,
        ST_RD_OP,
        ST_RD_AH,
        ST_RD_AL,
        ST_RD_DATA,
        ST_MK_CHK,
        ST_WE_OP,
        ST_WR_OP,
        ST_WR_AH,
        ST_WR_AL,
        ST_WR_MARK,
        ST_WR_FILL,
        ST_DONE
    } boot_st_e;

    typedef struct packed {
        logic done;
        logic fault;
        logic empty;
    } boot_flags_t;

    function automatic logic is_byte_step(input boot_st_e st);
        return !(st == ST_ID_CHK || st == ST_MK_CHK || st == ST_DONE);
    endfunction

    function automatic logic opens_frame(input boot_st_e st);
        return (st == ST_ID_OP) || (st == ST_RD_OP) ||
               (st == ST_WE_OP) || (st == ST_WR_OP);
    endfunction

    function automatic logic [7:0] step_byte(input boot_st_e st,
                                             input logic [7:0] marker);
        logic [7:0] b;
        case (st)
            ST_ID_OP:   b = OPC_READ_ID;
            ST_RD_OP:   b = OPC_READ;
            ST_WE_OP:   b = OPC_WR_EN;
            ST_WR_OP:   b = OPC_WRITE;
            ST_WR_MARK: b = marker;
            default:    b = FILL_BYTE;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/fram_spi_byte.sv
module fram_spi_byte #(
    parameter int SCK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic [7:0] tx_byte,
    output logic       ack,
    output logic [7:0] rx_byte,
    output logic       busy,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);

    localparam int DW = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(SCK_DIV - 1);

    logic [DW-1:0] div_cnt;
    logic [2:0]    bit_cnt;
    logic [7:0]    sh_q;
    logic [7:0]    rx_q;
    logic          sck_q;
    logic          busy_q;
    logic          ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            bit_cnt <= '0;
            sh_q    <= '0;
            rx_q    <= '0;
            sck_q   <= 1'b0;
            busy_q  <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            if (!busy_q) begin
                if (req) begin
                    busy_q  <= 1'b1;
                    sh_q    <= tx_byte;
                    div_cnt <= '0;
                    bit_cnt <= '0;
                    sck_q   <= 1'b0;
                end
            end else if (div_cnt == DIV_LAST) begin
                div_cnt <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rx_q  <= {rx_q[6:0], miso};
                end else begin
                    sck_q <= 1'b0;
                    if (bit_cnt == 3'd7) begin
                        busy_q <= 1'b0;
                        ack_q  <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                        sh_q    <= {sh_q[6:0], 1'b0};
                    end
                end
            end else begin
                div_cnt <= div_cnt + DW'(1);
            end
        end
    end

    assign ack     = ack_q;
    assign rx_byte = rx_q;
    assign busy    = busy_q;
    assign sck     = sck_q;
    assign mosi    = sh_q[7];

endmodule

// File: rtl/fram_cs_gap.sv
module fram_cs_gap #(
    parameter int GAP_CYCLES = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    output logic gap_ok
);

    localparam int GW = $clog2(GAP_CYCLES + 1) + 1;
    localparam logic [GW-1:0] GAP_LIM = GW'(GAP_CYCLES);

    logic [GW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!cs_n) begin
            cnt <= '0;
        end else if (cnt != GAP_LIM) begin
            cnt <= cnt + GW'(1);
        end
    end

    assign gap_ok = (cnt == GAP_LIM);

endmodule

// File: rtl/fram_boot_ctrl.sv
module fram_boot_ctrl
    import fram_boot_pkg::*;
#(
    parameter int          MEM_BYTES   = 8192,
    parameter logic [31:0] EXPECTED_ID = 32'h047F0302,
    parameter logic [7:0]  MARKER      = 8'd42,
    localparam int         AW          = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          gap_ok,
    output logic          cs_n,
    output logic          xfer_req,
    output logic [7:0]    xfer_tx,
    input  logic          xfer_ack,
    input  logic [7:0]    xfer_rx,
    output logic          done,
    output logic          dev_fault,
    output logic          empty,
    output logic [AW-1:0] next_free
);

    localparam int CW = AW + 1;
    localparam logic [CW-1:0] ID_LAST   = CW'(3);
    localparam logic [CW-1:0] FILL_LAST = CW'(MEM_BYTES - 2);

    boot_st_e    st;
    boot_flags_t flags;
    logic        cs_n_q;
    logic        req_q;
    logic [7:0]  tx_q;
    logic        waiting;
    logic [CW-1:0] cnt;
    logic [31:0] id_q;
    logic [7:0]  mark_q;
    logic [AW-1:0] free_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_ID_OP;
            flags   <= '0;
            cs_n_q  <= 1'b1;
            req_q   <= 1'b0;
            tx_q    <= '0;
            waiting <= 1'b0;
            cnt     <= '0;
            id_q    <= '0;
            mark_q  <= '0;
            free_q  <= '0;
        end else begin
            req_q <= 1'b0;
            if (is_byte_step(st)) begin
                if (!waiting) begin
                    if (cs_n_q) begin
                        if (opens_frame(st) && gap_ok) begin
                            cs_n_q <= 1'b0;
                        end
                    end else begin
                        req_q   <= 1'b1;
                        tx_q    <= step_byte(st, MARKER);
                        waiting <= 1'b1;
                    end
                end else if (xfer_ack) begin
                    waiting <= 1'b0;
                    case (st)
                        ST_ID_OP: begin
                            cnt <= '0;
                            st  <= ST_ID_DATA;
                        end
                        ST_ID_DATA: begin
                            id_q <= {id_q[23:0], xfer_rx};
                            if (cnt == ID_LAST) begin
                                cs_n_q <= 1'b1;
                                st     <= ST_ID_CHK;
                            end else begin
                                cnt <= cnt + CW'(1);
                            end
                        end
                        ST_RD_OP:   st <= ST_RD_AH;
                        ST_RD_AH:   st <= ST_RD_AL;
                        ST_RD_AL:   st <= ST_RD_DATA;
                        ST_RD_DATA: begin
                            mark_q <= xfer_rx;
                            cs_n_q <= 1'b1;
                            st     <= ST_MK_CHK;
                        end
                        ST_WE_OP: begin
                            cs_n_q <= 1'b1;
                            st     <= ST_WR_OP;
                        end
                        ST_WR_OP:   st <= ST_WR_AH;
                        ST_WR_AH:   st <= ST_WR_AL;
                        ST_WR_AL:   st <= ST_WR_MARK;
                        ST_WR_MARK: begin
                            cnt <= '0;
                            st  <= ST_WR_FILL;
                        end
                        ST_WR_FILL: begin
                            if (cnt == FILL_LAST) begin
                                cs_n_q <= 1'b1;
                                st     <= ST_DONE;
                            end else begin
                                cnt <= cnt + CW'(1);
                            end
                        end
                        default: st <= ST_DONE;
                    endcase
                end
            end else begin
                case (st)
                    ST_ID_CHK: begin
                        if (id_q == EXPECTED_ID) begin
                            st <= ST_RD_OP;
                        end else begin
                            flags.fault <= 1'b1;
                            st          <= ST_DONE;
                        end
                    end
                    ST_MK_CHK: begin
                        if (mark_q == MARKER) begin
                            st <= ST_DONE;
                        end else begin
                            flags.empty <= 1'b1;
                            st          <= ST_WE_OP;
                        end
                    end
                    default: begin
                        flags.done <= 1'b1;
                        if (!flags.fault) begin
                            free_q <= AW'(1);
                        end
                    end
                endcase
            end
        end
    end

    assign cs_n      = cs_n_q;
    assign xfer_req  = req_q;
    assign xfer_tx   = tx_q;
    assign done      = flags.done;
    assign dev_fault = flags.fault;
    assign empty     = flags.empty;
    assign next_free = free_q;

endmodule

// File: rtl/fram_boot_seq.sv
module fram_boot_seq #(
    parameter int          MEM_BYTES   = 8192,
    parameter int          SCK_DIV     = 4,
    parameter int          GAP_CYCLES  = 12,
    parameter logic [31:0] EXPECTED_ID = 32'h047F0302,
    parameter logic [7:0]  MARKER      = 8'd42,
    localparam int         ADDR_W      = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n,
    output logic              done,
    output logic              dev_fault,
    output logic              empty,
    output logic [ADDR_W-1:0] next_free
);

    logic       gap_ok;
    logic       xfer_req;
    logic [7:0] xfer_tx;
    logic       xfer_ack;
    logic [7:0] xfer_rx;
    logic       xfer_busy;
    logic       cs_n_int;

    fram_cs_gap #(
        .GAP_CYCLES(GAP_CYCLES)
    ) u_gap (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n_int),
        .gap_ok (gap_ok)
    );

    fram_boot_ctrl #(
        .MEM_BYTES   (MEM_BYTES),
        .EXPECTED_ID (EXPECTED_ID),
        .MARKER      (MARKER)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .gap_ok    (gap_ok),
        .cs_n      (cs_n_int),
        .xfer_req  (xfer_req),
        .xfer_tx   (xfer_tx),
        .xfer_ack  (xfer_ack),
        .xfer_rx   (xfer_rx),
        .done      (done),
        .dev_fault (dev_fault),
        .empty     (empty),
        .next_free (next_free)
    );

    fram_spi_byte #(
        .SCK_DIV(SCK_DIV)
    ) u_spi (
        .clk     (clk),
        .rst     (rst),
        .req     (xfer_req),
        .tx_byte (xfer_tx),
        .ack     (xfer_ack),
        .rx_byte (xfer_rx),
        .busy    (xfer_busy),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .miso    (spi_miso)
    );

    assign spi_cs_n = cs_n_int;

endmodule

// File: rtl/fram_boot_seq_chk.sv
module fram_boot_seq_chk #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic          sck,
    input logic          done,
    input logic          dev_fault,
    input logic          empty,
    input logic [AW-1:0] next_free,
    input logic          req,
    input logic          busy,
    input logic          gap_ok
);

    // R7: a frame opens only after the deselect timer has run out
    p_gap_before_frame_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> $past(gap_ok));

    // R8: completion is sticky and the result flags are frozen
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> done && $stable(dev_fault) && $stable(empty));

    // R8: success reports address 1 as first free location
    p_free_on_success_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !dev_fault) |-> next_free == AW'(1));

    // R3: a fault never coexists with a cleared array or an allocation base
    p_fault_clean_r3: assert property (@(posedge clk) disable iff (rst)
        dev_fault |-> (!empty && next_free == '0));

    // R9: serial clock stays low while deselected
    p_sck_idle_r9: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    // R10: requests only reach an idle engine
    p_req_idle_r10: assert property (@(posedge clk) disable iff (rst)
        req |-> !busy);

    // R10: every byte moves inside an open frame
    p_busy_selected_r10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cs_n);

endmodule

bind fram_boot_seq fram_boot_seq_chk #(
    .AW(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (spi_cs_n),
    .sck       (spi_sck),
    .done      (done),
    .dev_fault (dev_fault),
    .empty     (empty),
    .next_free (next_free),
    .req       (xfer_req),
    .busy      (xfer_busy),
    .gap_ok    (gap_ok)
);

// File: tb/fram_boot_seq_tb.sv
`timescale 1ns/100ps
module fram_boot_seq_tb;

    localparam int          MEM  = 64;
    localparam int          DIV  = 2;
    localparam int          GAP  = 12;
    localparam logic [31:0] GOOD = 32'h047F0302;
    localparam logic [7:0]  MK   = 8'd42;
    localparam int          AW   = $clog2(MEM);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          spi_sck, spi_mosi, spi_cs_n;
    logic          spi_miso = 1'b0;
    logic          done, dev_fault, empty;
    logic [AW-1:0] next_free;

    fram_boot_seq #(
        .MEM_BYTES  (MEM),
        .SCK_DIV    (DIV),
        .GAP_CYCLES (GAP),
        .EXPECTED_ID(GOOD),
        .MARKER     (MK)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .spi_sck   (spi_sck),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .spi_cs_n  (spi_cs_n),
        .done      (done),
        .dev_fault (dev_fault),
        .empty     (empty),
        .next_free (next_free)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    longint cyc  = 0;
    always @(negedge clk) cyc++;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // scoreboard of expected frames
    typedef struct {
        logic [7:0] op;
        int         len;
        string      tag;
    } frame_t;
    frame_t exp_q[$];

    task automatic expect_frame(input logic [7:0] op, input int len, input string tag);
        frame_t f;
        f.op = op; f.len = len; f.tag = tag;
        exp_q.push_back(f);
    endtask

    // memory device model
    logic [7:0]  mem [MEM];
    logic [7:0]  ref_mem [MEM];
    logic [31:0] model_id;
    logic        wel = 1'b0;
    int          bitc = 0, bytec = 0, addr = 0;
    logic [7:0]  inb = '0, op = '0, outsh = '0, nxt = '0;
    logic        ld = 1'b0, addr_nz = 1'b0;
    longint      rise_cyc = 0;

    always @(negedge spi_cs_n) begin
        if (!rst) begin
            check(cyc - rise_cyc >= GAP, "R7", "deselect cycles", cyc - rise_cyc, GAP);
        end
        bitc = 0; bytec = 0; outsh = '0; ld = 1'b0; addr_nz = 1'b0; op = '0;
        spi_miso = 1'b0;
    end

    always @(posedge spi_cs_n) begin
        rise_cyc = cyc;
        if (!rst) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 R5", "unexpected frame opcode", op, 0);
            end else begin
                frame_t f;
                f = exp_q.pop_front();
                check(op == f.op, {f.tag, " R9"}, "frame opcode", op, f.op);
                check(bytec == f.len, {f.tag, " R10"}, "frame byte count", bytec, f.len);
                if (op == 8'h03 || op == 8'h02)
                    check(!addr_nz, f.tag, "address bytes zero", addr_nz, 0);
            end
        end
        if (op == 8'h02) wel = 1'b0;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            inb = {inb[6:0], spi_mosi};
            bitc++;
            if (bitc == 8) begin
                bitc = 0;
                nxt = '0;
                if (bytec == 0) begin
                    op = inb;
                    if (op == 8'h06) wel = 1'b1;
                    if (op == 8'h9F) nxt = model_id[31:24];
                end else begin
                    case (op)
                        8'h9F: begin
                            if (bytec == 1) nxt = model_id[23:16];
                            else if (bytec == 2) nxt = model_id[15:8];
                            else if (bytec == 3) nxt = model_id[7:0];
                        end
                        8'h03, 8'h02: begin
                            if (bytec == 1) begin
                                addr = int'(inb) << 8;
                                if (inb != 0) addr_nz = 1'b1;
                            end else if (bytec == 2) begin
                                addr = addr | int'(inb);
                                if (inb != 0) addr_nz = 1'b1;
                            end else if (op == 8'h02) begin
                                if (wel) mem[addr % MEM] = inb;
                                addr++;
                            end
                            if (op == 8'h03 && bytec >= 2) begin
                                nxt = mem[addr % MEM];
                                addr++;
                            end
                        end
                        default: ;
                    endcase
                end
                bytec++;
                ld = 1'b1;
            end
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            if (ld) begin
                outsh = nxt;
                ld = 1'b0;
            end else begin
                outsh = {outsh[6:0], 1'b0};
            end
            spi_miso = outsh[7];
        end
    end

    task automatic run_case(input string name, input logic [31:0] id,
                            input logic [7:0] b0, input logic [7:0] rest,
                            input bit pattern, input bit want_fault, input bit want_fill);
        bit seen_done;
        $display("case %s", name);
        @(negedge clk);
        rst = 1'b1;
        exp_q.delete();
        model_id = id;
        wel = 1'b0;
        for (int i = 0; i < MEM; i++) begin
            mem[i] = pattern ? 8'(i * 3 + 1) : rest;
        end
        mem[0] = b0;
        for (int i = 0; i < MEM; i++) ref_mem[i] = mem[i];
        repeat (3) @(negedge clk);
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1", "bus idle in reset",
              {spi_cs_n, spi_sck}, 2'b10);
        check({done, dev_fault, empty} == 3'b000 && next_free == '0, "R1",
              "flags in reset", {done, dev_fault, empty, 8'(next_free)}, 0);
        rst = 1'b0;
        rise_cyc = cyc;
        expect_frame(8'h9F, 5, "R2");
        if (!want_fault) begin
            expect_frame(8'h03, 4, "R4");
            if (want_fill) begin
                expect_frame(8'h06, 1, "R6");
                expect_frame(8'h02, 3 + MEM, "R6");
            end
        end
        @(negedge clk);
        check(spi_cs_n == 1'b1 && done == 1'b0, "R1", "idle after reset release",
              {spi_cs_n, done}, 2'b10);
        seen_done = 1'b0;
        for (int k = 0; k < 30000 && !seen_done; k++) begin
            @(negedge clk);
            if (done) seen_done = 1'b1;
        end
        check(seen_done, "R8", "done reached", seen_done, 1);
        repeat (60) @(negedge clk);
        check(done == 1'b1, "R8", "done held", done, 1);
        check(exp_q.size() == 0, want_fault ? "R3" : (want_fill ? "R6" : "R5"),
              "frames outstanding", exp_q.size(), 0);
        check(dev_fault == want_fault, want_fault ? "R3" : "R2", "dev_fault",
              dev_fault, want_fault);
        check(empty == want_fill, want_fill ? "R6" : "R5", "empty", empty, want_fill);
        check(next_free == (want_fault ? AW'(0) : AW'(1)), want_fault ? "R3" : "R8",
              "next_free", next_free, want_fault ? 0 : 1);
        if (want_fill) begin
            int bad_loc;
            bad_loc = -1;
            for (int i = 1; i < MEM; i++) if (mem[i] != 8'h00 && bad_loc < 0) bad_loc = i;
            check(mem[0] == MK, "R6", "marker stored", mem[0], MK);
            check(bad_loc < 0, "R6", "first nonzero location", bad_loc, -1);
            check(mem[MEM-1] == 8'h00, "R6", "top location cleared", mem[MEM-1], 0);
        end else begin
            int diff;
            diff = -1;
            for (int i = 0; i < MEM; i++) if (mem[i] != ref_mem[i] && diff < 0) diff = i;
            check(diff < 0, want_fault ? "R3" : "R5", "memory untouched", diff, -1);
        end
    endtask

    initial begin
        run_case("marker present", GOOD, MK, 8'h00, 1'b1, 1'b0, 1'b0);
        run_case("marker stale", GOOD, 8'd7, 8'hA5, 1'b0, 1'b0, 1'b1);
        run_case("byte-swapped id", 32'h02037F04, MK, 8'h00, 1'b1, 1'b1, 1'b0);
        run_case("low byte id error", 32'h047F0303, 8'd7, 8'h00, 1'b1, 1'b1, 1'b0);
        run_case("blank array", GOOD, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1);
        run_case("marker present again", GOOD, MK, 8'h11, 1'b0, 1'b0, 1'b0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R8: actual=%0d expected=%0d", 150000, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule